// File: doc/BRIEF.md
# Gated Hub Charging Configuration Register

This block is one byte-wide configuration register inside a USB hub controller. An EEPROM loader or an SMBus host writes it, and its contents are always visible on a read bus. A mode input picks which of the two may write; writes from the other source are dropped. Two battery-charging control fields are normally read-only copies of fused one-time-programmable (OTP) bits. A custom-charging enable field in the same byte makes them writable. A write that sets the enable takes its new values for those two fields in that same write.

The power-enable polarity field is captured from the inverse of a strap pin while reset is held. After that, only a write from the active source can change it. From the effective charging fields and the upstream-connected status, the block decodes a one-hot charging mode {DCP, CDP, DIVIDER} for every downstream port that has charging enabled.

Top module: `hubcfg_reg`

## Requirements
- R1: While `rst` is high and on the first read after it falls, `rd_data_o` equals {0, 0, ~strap_pol_i, otp_hicur_i, 0, 0, otp_autoz_i, 0}, bit 7 first.
- R2: Bits 7 and 0 of `rd_data_o` always read 0, including after a write of 1s to them.
- R3: While bit 6 (custom enable) reads 0, bit 4 follows `otp_hicur_i` and bit 1 follows `otp_autoz_i`. A write with data bit 6 = 0 does not change what bits 4 and 1 read.
- R4: An accepted write whose data bit 6 is 1 stores data bits 4 and 1. From the next cycle, `rd_data_o` bits 6, 4 and 1 show the written values.
- R5: An accepted write stores data bits 6, 5, 3 and 2, which read back on the next cycle.
- R6: The source is chosen by `smbus_mode_i`. When it is 0 (I2C/EEPROM mode), only `eep_wr_i` with `eep_data_i` is accepted. When it is 1, only `smb_wr_i` with `smb_data_i` is accepted. A write from the other source leaves `rd_data_o` unchanged.
- R7: After an accepted write clears bit 6, bits 4 and 1 again follow the OTP inputs.
- R8: With `us_conn_i` = 0, the mode for a charging-enabled port is DIVIDER (3'b001) when bit 1 = 0 and bit 4 = 1. In every other case it is DCP (3'b100).
- R9: With `us_conn_i` = 1, the mode for a charging-enabled port is CDP (3'b010) when bit 1 = 1 and DCP (3'b100) when bit 1 = 0.
- R10: Port p uses `chg_mode_o[3p+2:3p]` in the order {DCP, CDP, DIVIDER}. The field is 3'b000 when `port_bc_en_i[p]` = 0 and exactly one-hot otherwise.
- R11: Bit 5 is taken from the strap only while reset is high. A strap change after reset has no effect on bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_pol_i | input | 1 | Power-polarity strap pin level |
| otp_hicur_i | input | 1 | Fused high-current divider enable |
| otp_autoz_i | input | 1 | Fused automatic-mode disable (active-low enable) |
| smbus_mode_i | input | 1 | 1 = SMBus host writes, 0 = EEPROM loader writes |
| eep_wr_i | input | 1 | EEPROM loader write strobe |
| eep_data_i | input | 8 | EEPROM loader write data |
| smb_wr_i | input | 1 | SMBus host write strobe |
| smb_data_i | input | 8 | SMBus host write data |
| us_conn_i | input | 1 | Upstream port connected |
| port_bc_en_i | input | NPORTS | Per-port charging enable |
| rd_data_o | output | 8 | Register read value |
| chg_mode_o | output | 3*NPORTS | Per-port one-hot charging mode |

## Verification
On every cycle the assertions check four things: the reserved bits read zero, bits 4 and 1 mirror the OTP inputs while the custom enable is clear, a write that sets the enable lands its charging fields in the same write, and every enabled port's mode is one-hot. They also check that dropped writes leave the stored fields unchanged. Only the bench scenarios show that the strap is captured at reset and ignored afterwards, and that bits 4 and 1 fall back to the OTP values once the enable is cleared. The scenarios also walk the full decode table across upstream-connected and disconnected states.

// File: rtl/hubcfg_pkg.sv
package hubcfg_pkg;

    localparam int REG_W   = 8;
    localparam int MODE_W  = 3;

    localparam int B_CUSTOM = 6;
    localparam int B_POL    = 5;
    localparam int B_HICUR  = 4;
    localparam int B_RSV3   = 3;
    localparam int B_FEAT2  = 2;
    localparam int B_AUTOZ  = 1;

    typedef logic [MODE_W-1:0] chg_t;
    localparam chg_t CHG_OFF = 3'b000;
    localparam chg_t CHG_DCP = 3'b100;
    localparam chg_t CHG_CDP = 3'b010;
    localparam chg_t CHG_DIV = 3'b001;

    typedef struct packed {
        logic custom;
        logic pol;
        logic hicur;
        logic rsv3;
        logic feat2;
        logic autoz;
    } cfg_t;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] data;
    } wr_t;

    function automatic chg_t chg_decode(input logic conn, input logic autoz,
                                        input logic hicur);
        chg_t m;
        if (conn)
            m = autoz ? CHG_CDP : CHG_DCP;
        else if (!autoz && hicur)
            m = CHG_DIV;
        else
            m = CHG_DCP;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_byte(input cfg_t c);
        logic [REG_W-1:0] b;
        b           = '0;
        b[B_CUSTOM] = c.custom;
        b[B_POL]    = c.pol;
        b[B_HICUR]  = c.hicur;
        b[B_RSV3]   = c.rsv3;
        b[B_FEAT2]  = c.feat2;
        b[B_AUTOZ]  = c.autoz;
        return b;
    endfunction

endpackage

// File: rtl/hubcfg_wr_arb.sv
module hubcfg_wr_arb
    import hubcfg_pkg::*;
(
    input  logic             smbus_mode_i,
    input  logic             eep_wr_i,
    input  logic [REG_W-1:0] eep_data_i,
    input  logic             smb_wr_i,
    input  logic [REG_W-1:0] smb_data_i,
    output wr_t              wr_o
);
    always_comb begin
        if (smbus_mode_i) begin
            wr_o.en   = smb_wr_i;
            wr_o.data = smb_data_i;
        end else begin
            wr_o.en   = eep_wr_i;
            wr_o.data = eep_data_i;
        end
    end
endmodule

// File: rtl/hubcfg_store.sv
module hubcfg_store
    import hubcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strap_pol_i,
    input  logic otp_hicur_i,
    input  logic otp_autoz_i,
    input  wr_t  wr_i,
    output cfg_t eff_o
);
    cfg_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.pol <= ~strap_pol_i;
        end else if (wr_i.en) begin
            q.custom <= wr_i.data[B_CUSTOM];
            q.pol    <= wr_i.data[B_POL];
            q.rsv3   <= wr_i.data[B_RSV3];
            q.feat2  <= wr_i.data[B_FEAT2];
            if (wr_i.data[B_CUSTOM]) begin
                q.hicur <= wr_i.data[B_HICUR];
                q.autoz <= wr_i.data[B_AUTOZ];
            end
        end
    end

    always_comb begin
        eff_o = q;
        if (!q.custom) begin
            eff_o.hicur = otp_hicur_i;
            eff_o.autoz = otp_autoz_i;
        end
    end
endmodule

// File: rtl/hubcfg_chg_decode.sv
module hubcfg_chg_decode
    import hubcfg_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  cfg_t                     eff_i,
    input  logic                     us_conn_i,
    input  logic [NPORTS-1:0]        port_bc_en_i,
    output logic [MODE_W*NPORTS-1:0] chg_mode_o
);
    chg_t common;
    assign common = chg_decode(us_conn_i, eff_i.autoz, eff_i.hicur);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign chg_mode_o[MODE_W*p +: MODE_W] = port_bc_en_i[p] ? common : CHG_OFF;
    end
endmodule

// File: rtl/hubcfg_reg.sv
module hubcfg_reg
    import hubcfg_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strap_pol_i,
    input  logic                     otp_hicur_i,
    input  logic                     otp_autoz_i,
    input  logic                     smbus_mode_i,
    input  logic                     eep_wr_i,
    input  logic [REG_W-1:0]         eep_data_i,
    input  logic                     smb_wr_i,
    input  logic [REG_W-1:0]         smb_data_i,
    input  logic                     us_conn_i,
    input  logic [NPORTS-1:0]        port_bc_en_i,
    output logic [REG_W-1:0]         rd_data_o,
    output logic [MODE_W*NPORTS-1:0] chg_mode_o
);
    wr_t  wr;
    cfg_t eff;

    hubcfg_wr_arb u_arb (
        .smbus_mode_i (smbus_mode_i),
        .eep_wr_i     (eep_wr_i),
        .eep_data_i   (eep_data_i),
        .smb_wr_i     (smb_wr_i),
        .smb_data_i   (smb_data_i),
        .wr_o         (wr)
    );

    hubcfg_store u_store (
        .clk         (clk),
        .rst         (rst),
        .strap_pol_i (strap_pol_i),
        .otp_hicur_i (otp_hicur_i),
        .otp_autoz_i (otp_autoz_i),
        .wr_i        (wr),
        .eff_o       (eff)
    );

    hubcfg_chg_decode #(.NPORTS(NPORTS)) u_dec (
        .eff_i        (eff),
        .us_conn_i    (us_conn_i),
        .port_bc_en_i (port_bc_en_i),
        .chg_mode_o   (chg_mode_o)
    );

    assign rd_data_o = cfg_to_byte(eff);
endmodule

// File: rtl/hubcfg_reg_chk.sv
module hubcfg_reg_chk
    import hubcfg_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     otp_hicur_i,
    input logic                     otp_autoz_i,
    input logic                     smbus_mode_i,
    input logic                     eep_wr_i,
    input logic [REG_W-1:0]         eep_data_i,
    input logic                     smb_wr_i,
    input logic [REG_W-1:0]         smb_data_i,
    input logic                     us_conn_i,
    input logic [NPORTS-1:0]        port_bc_en_i,
    input logic [REG_W-1:0]         rd_data_o,
    input logic [MODE_W*NPORTS-1:0] chg_mode_o
);
    logic             take;
    logic [REG_W-1:0] din;
    assign take = smbus_mode_i ? smb_wr_i : eep_wr_i;
    assign din  = smbus_mode_i ? smb_data_i : eep_data_i;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[7] == 1'b0 && rd_data_o[0] == 1'b0); // R2

    AST_OTP_MIRROR: assert property (@(posedge clk) disable iff (rst)
        !rd_data_o[B_CUSTOM] |->
            (rd_data_o[B_HICUR] == otp_hicur_i && rd_data_o[B_AUTOZ] == otp_autoz_i)); // R3

    AST_SAME_WRITE: assert property (@(posedge clk) disable iff (rst)
        (take && din[B_CUSTOM]) |=>
            (rd_data_o[B_CUSTOM] && rd_data_o[B_HICUR] == $past(din[B_HICUR])
             && rd_data_o[B_AUTOZ] == $past(din[B_AUTOZ]))); // R4

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(rd_data_o[B_CUSTOM]) && $stable(rd_data_o[B_POL])
                   && $stable(rd_data_o[B_RSV3]) && $stable(rd_data_o[B_FEAT2]))); // R6

    AST_CDP_CONN: assert property (@(posedge clk) disable iff (rst)
        (us_conn_i && rd_data_o[B_AUTOZ] && port_bc_en_i[0]) |->
            chg_mode_o[MODE_W-1:0] == CHG_CDP); // R9

    for (genvar p = 0; p < NPORTS; p++) begin : g_oh
        AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $countones(chg_mode_o[MODE_W*p +: MODE_W]) == (port_bc_en_i[p] ? 1 : 0)); // R10
    end
endmodule

bind hubcfg_reg hubcfg_reg_chk #(.NPORTS(NPORTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .otp_hicur_i  (otp_hicur_i),
    .otp_autoz_i  (otp_autoz_i),
    .smbus_mode_i (smbus_mode_i),
    .eep_wr_i     (eep_wr_i),
    .eep_data_i   (eep_data_i),
    .smb_wr_i     (smb_wr_i),
    .smb_data_i   (smb_data_i),
    .us_conn_i    (us_conn_i),
    .port_bc_en_i (port_bc_en_i),
    .rd_data_o    (rd_data_o),
    .chg_mode_o   (chg_mode_o)
);

// File: tb/hubcfg_reg_tb.sv
module hubcfg_reg_tb;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap = 1'b1;
    logic          otp_h = 1'b1;
    logic          otp_a = 1'b0;
    logic          smode = 1'b0;
    logic          ewr = 1'b0, swr = 1'b0;
    logic [7:0]    edat = '0, sdat = '0;
    logic          conn = 1'b0;
    logic [NP-1:0] bcen = '1;
    logic [7:0]    rd;
    logic [3*NP-1:0] chg;

    always #5 clk = ~clk;

    hubcfg_reg #(.NPORTS(NP)) u_dut (
        .clk(clk), .rst(rst), .strap_pol_i(strap), .otp_hicur_i(otp_h),
        .otp_autoz_i(otp_a), .smbus_mode_i(smode), .eep_wr_i(ewr),
        .eep_data_i(edat), .smb_wr_i(swr), .smb_data_i(sdat),
        .us_conn_i(conn), .port_bc_en_i(bcen), .rd_data_o(rd), .chg_mode_o(chg)
    );

    // behavioural reference state
    bit m_cus, m_pol, m_hi, m_r3, m_f2, m_az;
    bit started = 0;
    int vectors = 0, errors = 0;
    string req = "R1";

    always @(posedge clk) begin
        bit       w;
        bit [7:0] d;
        w = smode ? swr : ewr;
        d = smode ? sdat : edat;
        if (rst) begin
            {m_cus, m_hi, m_r3, m_f2, m_az} = '0;
            m_pol = !strap;
        end else if (w) begin
            m_cus = d[6]; m_pol = d[5]; m_r3 = d[3]; m_f2 = d[2];
            if (d[6]) begin m_hi = d[4]; m_az = d[1]; end
        end
        started = 1;
    end

    function automatic bit [7:0] exp_rd();
        bit h, a;
        h = m_cus ? m_hi : otp_h;
        a = m_cus ? m_az : otp_a;
        return {1'b0, m_cus, m_pol, h, m_r3, m_f2, a, 1'b0};
    endfunction

    function automatic bit [3*NP-1:0] exp_chg(bit [7:0] r);
        bit [2:0] m;
        bit [3*NP-1:0] v;
        if (conn)                m = r[1] ? 3'b010 : 3'b100;
        else if (!r[1] && r[4])  m = 3'b001;
        else                     m = 3'b100;
        for (int p = 0; p < NP; p++) v[3*p +: 3] = bcen[p] ? m : 3'b000;
        return v;
    endfunction

    always @(negedge clk) begin
        if (started) begin
            bit [7:0] er;
            bit [3*NP-1:0] ec;
            er = exp_rd();
            ec = exp_chg(er);
            vectors++;
            if (rd !== er) begin
                errors++;
                $display("FAIL %s rd_data actual=%h expected=%h t=%0t", req, rd, er, $time);
            end
            if (chg !== ec) begin
                errors++;
                $display("FAIL %s chg_mode actual=%h expected=%h t=%0t", req, chg, ec, $time);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic ewrite(bit [7:0] d);
        edat = d; ewr = 1'b1; step(); ewr = 1'b0; step();
    endtask

    task automatic swrite(bit [7:0] d);
        sdat = d; swr = 1'b1; step(); swr = 1'b0; step();
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        req = "R1"; step(3); rst = 1'b0; step(2);
        req = "R11"; strap = 1'b0; step(2); strap = 1'b1; step();
        req = "R3"; otp_h = 1'b0; otp_a = 1'b1; step(); otp_a = 1'b0; otp_h = 1'b1; step();
        req = "R5"; ewrite(8'h2C);
        req = "R3"; ewrite(8'h12); otp_h = 1'b0; step(); otp_h = 1'b1; step();
        req = "R4"; ewrite(8'h52);
        req = "R9"; conn = 1'b1; step(2);
        req = "R6"; swrite(8'h00); step();
        req = "R8"; conn = 1'b0; step(2);
        req = "R4"; ewrite(8'h50);
        req = "R8"; step(2);
        req = "R9"; conn = 1'b1; step(2);
        req = "R10"; bcen = 4'b0101; step(2); bcen = 4'b0000; step(); bcen = '1; step();
        req = "R4"; ewrite(8'h40); conn = 1'b0; step(2);
        req = "R2"; ewrite(8'hFF); step();
        req = "R7"; ewrite(8'h00); otp_a = 1'b1; step(); otp_a = 1'b0; step();
        req = "R6"; smode = 1'b1; ewrite(8'h7E); step();
        req = "R5"; swrite(8'h6C);
        req = "R4"; swrite(8'h52); conn = 1'b1; step(2);
        req = "R7"; swrite(8'h00); step(2);
        req = "R1"; strap = 1'b0; rst = 1'b1; step(2); rst = 1'b0; step(2);
        req = "R11"; strap = 1'b1; step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule